// File: doc/BRIEF.md
# Programmable memory card clock generator

This block turns a fast function clock into the much slower clock that paces a memory card. Software sets three fields in one 32-bit control word through a small synchronous register port. An 8-bit rate value picks the divisor. A family bit switches the divisor from 2×(rate+1) to 4×(rate+1). A run bit gates the output pin.

The output is a registered square wave with a 50% duty cycle. A three-state machine produces it and walks through `ST_OFF`, `ST_LOW` and `ST_HIGH`. The transitions are:

- `ST_OFF` to `ST_LOW` when the run bit is seen set.
- `ST_LOW` to `ST_HIGH` when the low-phase counter expires.
- `ST_LOW` to `ST_OFF` as soon as the run bit is seen clear.
- `ST_HIGH` to `ST_LOW` when the high-phase counter expires and the run bit is set.
- `ST_HIGH` to `ST_OFF` when the high-phase counter expires and the run bit is clear.

New rate and family settings are captured only when a low phase begins. A running clock therefore never shows a truncated half-period. Turning the block off never cuts a high pulse short.

Top module: `card_clk_gen`

## Requirements
- R1: With the family bit (control bit 9) clear, the output period is 2×(rate+1) function-clock cycles, where rate is control bits 7:0. The output is high for exactly rate+1 of those cycles.
- R2: With the family bit set, the output period is 4×(rate+1) cycles. The output is high for 2×(rate+1) of them.
- R3: While the run bit (control bit 8) is clear and the output is low, the output stays low.
- R4: Control bits 31:10 always read as zero, and writes to them are dropped.
- R5: After reset, the control word reads 0x000000FF and the output is low.
- R6: When the run bit is cleared during a high phase, that high phase still lasts its full length before the output is held low.
- R7: When the run bit is set from the idle state, the output first shows a full low phase. The first high sample comes half+1 cycles after the write edge, where half is the high-phase length from R1 or R2. The output can only rise while the run bit is set.
- R8: A change to rate or the family bit written during a high phase does not alter that phase. The following low phase and all later phases use the new value.
- R9: A write with write-enable set at word address CTRL_ADDR (0) updates the control word on that clock edge. Read data is registered and shows the addressed word one cycle after the address is presented. Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| card_clk | output | 1 | Divided card clock, low while stopped |

## Verification
A register write lands on the clock edge where write-enable is sampled. The state machine sees the new value one edge later. After an enable from idle, the first high output is therefore due half+1 cycles after the write edge, and read data is due one cycle after its address. The bench drives inputs on falling edges and samples on falling edges. It counts these latencies exactly rather than waiting for a change. Before measuring a period after a configuration change, it first waits for a falling output transition, so that the measured high and low phases are the first ones built from the new setting. For the disable and rate-change cases, it counts high samples from the rising edge seen just before the write.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
    localparam int unsigned RATE_W   = 8;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned BIT_RUN  = RATE_W;
    localparam int unsigned BIT_QUAD = RATE_W + 1;
    localparam int unsigned HALF_W   = RATE_W + 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic              quad;
        logic              run;
        logic [RATE_W-1:0] rate;
    } ctrl_t;
endpackage

// File: rtl/card_clk_regs.sv
module card_clk_regs
    import card_clk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

    logic             hit;
    logic [REG_W-1:0] view;

    assign hit = (addr == SEL);

    always_comb begin
        view              = '0;
        view[RATE_W-1:0]  = ctrl.rate;
        view[BIT_RUN]     = ctrl.run;
        view[BIT_QUAD]    = ctrl.quad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.rate <= '1;
            ctrl.run  <= 1'b0;
            ctrl.quad <= 1'b0;
            rdata     <= '0;
        end else begin
            if (we && hit) begin
                ctrl.rate <= wdata[RATE_W-1:0];
                ctrl.run  <= wdata[BIT_RUN];
                ctrl.quad <= wdata[BIT_QUAD];
            end
            rdata <= hit ? view : '0;
        end
    end
endmodule

// File: rtl/card_clk_half.sv
module card_clk_half
    import card_clk_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    input  logic              quad,
    output logic [HALF_W-1:0] half_m1
);
    // half - 1: rate for the /2 family, 2*rate+1 for the /4 family
    assign half_m1 = quad ? {rate, 1'b1} : {1'b0, rate};
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import card_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              clk_o
);
    phase_e            state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] hold_q, hold_d;
    logic              expired;

    assign expired = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = expired ? cnt_q : cnt_q - 1'b1;
        hold_d  = hold_q;
        unique case (state_q)
            ST_OFF: begin
                if (run) begin
                    state_d = ST_LOW;
                    cnt_d   = half_m1;
                    hold_d  = half_m1;
                end
            end
            ST_LOW: begin
                if (!run) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (expired) begin
                    state_d = ST_HIGH;
                    cnt_d   = hold_q;
                end
            end
            ST_HIGH: begin
                if (expired) begin
                    if (run) begin
                        state_d = ST_LOW;
                        cnt_d   = half_m1;
                        hold_d  = half_m1;
                    end else begin
                        state_d = ST_OFF;
                    end
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        clk_o = (state_q == ST_HIGH);
    end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import card_clk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              card_clk
);
    ctrl_t             ctrl_q;
    logic [HALF_W-1:0] half_m1;

    card_clk_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctrl  (ctrl_q),
        .rdata (reg_rdata)
    );

    card_clk_half i_half (
        .rate    (ctrl_q.rate),
        .quad    (ctrl_q.quad),
        .half_m1 (half_m1)
    );

    card_clk_div i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .half_m1 (half_m1),
        .clk_o   (card_clk)
    );
endmodule

module card_clk_chk #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              card_clk,
    input logic              run
);
    a_r3_off_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !card_clk) |=> !card_clk);

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:10] == '0);

    a_r7_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(run));

    a_r9_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_addr) != ADDR_W'(CTRL_ADDR)) |-> (reg_rdata == '0));
endmodule

bind card_clk_gen card_clk_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .card_clk  (card_clk),
    .run       (ctrl_q.run)
);

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              card_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    card_clk_gen #(.ADDR_W(ADDR_W), .CTRL_ADDR(0)) i_card_clk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .card_clk  (card_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_rise();
        logic prev = card_clk;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (card_clk && !prev) return;
            prev = card_clk;
        end
    endtask

    task automatic wait_fall();
        logic prev = card_clk;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!card_clk && prev) return;
            prev = card_clk;
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (card_clk == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int exp_half, input string tag);
        int hi, lo;
        wait_fall();
        wait_rise();
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        check(hi == exp_half, {tag, " high phase"}, hi, exp_half);
        check(lo == exp_half, {tag, " low phase"}, lo, exp_half);
    endtask

    task automatic stop_and_idle();
        int hi;
        wr(0, 32'h0);
        count_level(1'b1, hi);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(card_clk == 1'b0, "R5 output low after reset", card_clk, 0);
        rd(0, d);
        check(d == 32'h0000_00FF, "R5 reset control word", d, 32'hFF);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(0, 32'hFFFF_FC12);
        rd(0, d);
        check(d == 32'h0000_0012, "R4 reserved bits dropped", d, 32'h12);
        wr(3, 32'h0000_0155);
        rd(0, d);
        check(d == 32'h0000_0012, "R9 other address write ignored", d, 32'h12);
        rd(3, d);
        check(d == 32'h0, "R9 other address reads zero", d, 0);
        check(card_clk == 1'b0, "R3 output low while run clear", card_clk, 0);
        wr(0, 32'h0000_0000);
    endtask

    task automatic t_div2();
        wr(0, 32'h0000_0100);
        measure(1, "R1 rate0");
        wr(0, 32'h0000_0103);
        measure(4, "R1 rate3");
        wr(0, 32'h0000_01FF);
        measure(256, "R1 rate255");
        stop_and_idle();
    endtask

    task automatic t_div4();
        wr(0, 32'h0000_0300);
        measure(2, "R2 rate0");
        wr(0, 32'h0000_0303);
        measure(8, "R2 rate3");
        wr(0, 32'h0000_03FF);
        measure(512, "R2 rate255");
        stop_and_idle();
    endtask

    task automatic t_start();
        int lo;
        wr(0, 32'h0000_0106);
        count_level(1'b0, lo);
        check(lo == 8, "R7 first low phase from idle", lo, 8);
        stop_and_idle();
        wr(0, 32'h0000_0302);
        count_level(1'b0, lo);
        check(lo == 7, "R7 first low phase from idle /4", lo, 7);
        stop_and_idle();
    endtask

    task automatic t_stop();
        int hi, lo;
        bit stayed;
        wr(0, 32'h0000_0104);
        wait_rise();
        wr(0, 32'h0000_0004);
        count_level(1'b1, hi);
        check(hi == 4, "R6 high phase completes after disable", hi + 1, 5);
        stayed = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (card_clk) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed, "R3 held low while disabled", !stayed, 0);
    endtask

    task automatic t_change();
        int hi, lo, hi2;
        wr(0, 32'h0000_0102);
        measure(3, "R8 setup");
        wait_rise();
        wr(0, 32'h0000_0105);
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        count_level(1'b1, hi2);
        check(hi + 1 == 3, "R8 current high phase unchanged", hi + 1, 3);
        check(lo == 6, "R8 next low uses new rate", lo, 6);
        check(hi2 == 6, "R8 next high uses new rate", hi2, 6);
        wr(0, 32'h0000_0305);
        measure(12, "R8 family switch");
        stop_and_idle();
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_div2();
        t_div4();
        t_start();
        t_stop();
        t_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule